// File: doc/BRIEF.md
# Link Reset Quiesce Handshake Controller

This block sits between a PCIe-style link core and an application bridge and decides when the application may send and receive packets around resets. Two asynchronous sources can hold the block in reset. One is the active-low fundamental reset. The other is an active-low configuration-done indication, which holds the block in reset while it reads 1. Both sources are synchronized into the application clock domain. The block then reports an active-low, clock-synchronous reset status, which stays low until both sources are released and the link core signals that it is up.

When the link core warns that a warm reset is coming, the block closes both packet paths and starts a flush. The flush waits until every transmitted packet has been drained and every tag has been returned, or until a timeout expires. The block then pulses a clear strobe for the link-facing registers, queues and tag pool and raises a ready-for-reset acknowledge. The acknowledge holds until the request is withdrawn. After that, transmission stays closed until a new rising edge of the bus-master-enable bit. A level that was already high does not reopen the path. Received packets are discarded whenever the path is not running.

Top module: `link_quiesce_ctrl`

## Requirements
- R1: `resetStatusN` is 0 while `fundRstN` is 0, `cfgDoneN` is 1 or `coreReady` is 0. After both asynchronous sources are released with `coreReady` at 1, `resetStatusN` rises on the third rising clock edge: two synchronizer stages plus one state step.
- R2: Driving `fundRstN` low forces `resetStatusN`, `linkTxValid` and `appRxValid` to 0 without waiting for a clock edge.
- R3: `stateClear` is 1 in every cycle in which `resetStatusN` is 0.
- R4: On leaving reset, transmission stays closed even if `busMasterEn` is already 1. It opens in the cycle after a clock edge at which `busMasterEn` is 1, having been 0 at the previous edge.
- R5: `appRxValid` equals `rxValid` only while the path is running and `rstReqN` is 1. In any other case `appRxValid` is 0.
- R6: While running, `linkTxValid` follows `txValid`. The exceptions are when the outstanding count equals MAX_OUT, or when `txNeedsTag` is 1 and the tag count equals NUM_TAGS. The outstanding count goes up by one per forwarded packet and down by one per `txDrained` pulse while nonzero. The tag count goes up per forwarded packet with `txNeedsTag` and down per `tagRetire` pulse while nonzero.
- R7: In a cycle with `rstReqN` at 0, neither `linkTxValid` nor `appRxValid` is asserted, and the block enters the flush state at the next edge.
- R8: In the flush state, `warmRstRdy` rises one cycle after the cycle in which both counts are zero.
- R9: If the counts do not reach zero, `warmRstRdy` rises TIMEOUT_CYC cycles after flush entry.
- R10: `stateClear` is high for exactly the cycle that ends the flush, and both counts restart from zero afterwards.
- R11: `warmRstRdy` stays 1 until `rstReqN` returns to 1. The block then waits for a fresh rising edge of `busMasterEn` before any packet is forwarded.
- R12: `coreReady` at 0 at any clock edge returns the block to reset, so `resetStatusN` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Application clock |
| fundRstN | input | 1 | Fundamental reset, active low, asynchronous |
| cfgDoneN | input | 1 | Configuration done, active low; 1 holds the block in reset |
| coreReady | input | 1 | Link core reports it is out of reset |
| rstReqN | input | 1 | Warm reset imminent request from the link core, active low |
| busMasterEn | input | 1 | Bus-master-enable bit |
| txValid | input | 1 | Application offers a transmit packet |
| txNeedsTag | input | 1 | Offered packet consumes a tag |
| txDrained | input | 1 | One forwarded packet has left the core |
| tagRetire | input | 1 | One tag has been returned |
| rxValid | input | 1 | Receive packet from the link core |
| linkTxValid | output | 1 | Gated transmit strobe toward the link core |
| appRxValid | output | 1 | Gated receive strobe toward the application |
| resetStatusN | output | 1 | Synchronized reset status, active low |
| warmRstRdy | output | 1 | Ready-for-warm-reset acknowledge |
| stateClear | output | 1 | Clear for link registers, queues and tag pool |

## Verification
A warm reset request can arrive in the same cycle as a transmit or receive strobe, or in the same cycle as a fresh bus-master-enable edge. In both cases the request must win, so neither strobe leaks through and the path does not open. The directed sequence lowers `rstReqN` in a cycle with `txValid` and `rxValid` high. The random phase toggles the request, the enable bit and both packet strobes independently, so the collisions occur many times. A cycle-level reference model built from the requirements judges every output in every cycle.

// File: rtl/lqc_pkg.sv
package lqc_pkg;

  typedef enum logic [2:0] {
    ST_RESET    = 3'd0,
    ST_WAIT_BME = 3'd1,
    ST_RUN      = 3'd2,
    ST_FLUSH    = 3'd3,
    ST_ACK      = 3'd4
  } lqcState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;       // wipe counters (reset or end of flush)
    logic txOpen;      // transmit path may forward
    logic rxOpen;      // receive path may deliver
    logic countTimer;  // flush timer runs
  } lqcStrobe_t;

endpackage

// File: rtl/lqc_rst_sync.sv
module lqc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arstN,
  output logic syncRstN
);
  logic [STAGES-1:0] chain;

  // Assert at once, release after STAGES edges
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign syncRstN = chain[STAGES-1];
endmodule

// File: rtl/lqc_occupancy.sv
module lqc_occupancy #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic inc,
  input  logic dec,
  output logic full,
  output logic empty
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

  logic [CNT_W-1:0] count;
  logic doInc, doDec;

  assign full  = (count == LIMIT_V);
  assign empty = (count == '0);
  assign doInc = inc && !full;
  assign doDec = dec && !empty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                count <= '0;
    else if (clr)             count <= '0;
    else if (doInc && !doDec) count <= count + CNT_W'(1);
    else if (doDec && !doInc) count <= count - CNT_W'(1);
  end
endmodule

// File: rtl/lqc_datapath.sv
module lqc_datapath
  import lqc_pkg::*;
#(
  parameter int MAX_OUT     = 32,
  parameter int NUM_TAGS    = 16,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  lqcStrobe_t strobe,
  input  logic       txValid,
  input  logic       txNeedsTag,
  input  logic       txDrained,
  input  logic       tagRetire,
  input  logic       rxValid,
  output logic       linkTxValid,
  output logic       appRxValid,
  output logic       drained,
  output logic       timedOut
);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);

  logic outFull, outEmpty, tagFull, tagEmpty;
  logic [TMR_W-1:0] flushTimer;

  assign linkTxValid = txValid && strobe.txOpen && !outFull
                       && (!txNeedsTag || !tagFull);
  assign appRxValid  = rxValid && strobe.rxOpen;

  lqc_occupancy #(.LIMIT(MAX_OUT)) outTrack (
    .clk  (clk),
    .rstN (rstN),
    .clr  (strobe.clear),
    .inc  (linkTxValid),
    .dec  (txDrained),
    .full (outFull),
    .empty(outEmpty)
  );

  lqc_occupancy #(.LIMIT(NUM_TAGS)) tagTrack (
    .clk  (clk),
    .rstN (rstN),
    .clr  (strobe.clear),
    .inc  (linkTxValid && txNeedsTag),
    .dec  (tagRetire),
    .full (tagFull),
    .empty(tagEmpty)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  flushTimer <= '0;
    else if (strobe.countTimer) flushTimer <= flushTimer + TMR_W'(1);
    else                        flushTimer <= '0;
  end

  assign drained  = outEmpty && tagEmpty;
  assign timedOut = (flushTimer == TMR_LAST);
endmodule

// File: rtl/lqc_ctrl.sv
module lqc_ctrl
  import lqc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       coreReady,
  input  logic       rstReqN,
  input  logic       busMasterEn,
  input  logic       drained,
  input  logic       timedOut,
  output lqcStrobe_t strobe,
  output logic       resetStatusN,
  output logic       warmRstRdy
);
  lqcState_e state, stateNext;
  logic bmePrev, bmeRise, flushDone;

  // Previous value resets high so a stale enable is not an edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bmePrev <= 1'b1;
    else       bmePrev <= busMasterEn;
  end
  assign bmeRise = busMasterEn && !bmePrev;

  assign flushDone = (state == ST_FLUSH) && (drained || timedOut);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RESET:    stateNext = ST_WAIT_BME;
      ST_WAIT_BME: if (!rstReqN)     stateNext = ST_FLUSH;
                   else if (bmeRise) stateNext = ST_RUN;
      ST_RUN:      if (!rstReqN)     stateNext = ST_FLUSH;
      ST_FLUSH:    if (flushDone)    stateNext = ST_ACK;
      ST_ACK:      if (rstReqN)      stateNext = ST_WAIT_BME;
      default:     stateNext = ST_RESET;
    endcase
    if (!coreReady) stateNext = ST_RESET;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RESET;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.clear      = (state == ST_RESET) || flushDone;
    strobe.txOpen     = (state == ST_RUN) && rstReqN;
    strobe.rxOpen     = (state == ST_RUN) && rstReqN;
    strobe.countTimer = (state == ST_FLUSH);
  end

  assign resetStatusN = (state != ST_RESET);
  assign warmRstRdy   = (state == ST_ACK);
endmodule

// File: rtl/link_quiesce_ctrl.sv
module link_quiesce_ctrl
  import lqc_pkg::*;
#(
  parameter int MAX_OUT     = 32,
  parameter int NUM_TAGS    = 16,
  parameter int TIMEOUT_CYC = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic fundRstN,
  input  logic cfgDoneN,
  input  logic coreReady,
  input  logic rstReqN,
  input  logic busMasterEn,
  input  logic txValid,
  input  logic txNeedsTag,
  input  logic txDrained,
  input  logic tagRetire,
  input  logic rxValid,
  output logic linkTxValid,
  output logic appRxValid,
  output logic resetStatusN,
  output logic warmRstRdy,
  output logic stateClear
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0] srcRstN, syncRstN;
  logic rstN, drained, timedOut;
  lqcStrobe_t strobe;

  assign srcRstN = {~cfgDoneN, fundRstN};

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSync
    lqc_rst_sync #(.STAGES(SYNC_STAGES)) syncInst (
      .clk     (clk),
      .arstN   (srcRstN[g]),
      .syncRstN(syncRstN[g])
    );
  end

  assign rstN = &syncRstN;

  lqc_ctrl ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .coreReady   (coreReady),
    .rstReqN     (rstReqN),
    .busMasterEn (busMasterEn),
    .drained     (drained),
    .timedOut    (timedOut),
    .strobe      (strobe),
    .resetStatusN(resetStatusN),
    .warmRstRdy  (warmRstRdy)
  );

  lqc_datapath #(
    .MAX_OUT    (MAX_OUT),
    .NUM_TAGS   (NUM_TAGS),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .txValid    (txValid),
    .txNeedsTag (txNeedsTag),
    .txDrained  (txDrained),
    .tagRetire  (tagRetire),
    .rxValid    (rxValid),
    .linkTxValid(linkTxValid),
    .appRxValid (appRxValid),
    .drained    (drained),
    .timedOut   (timedOut)
  );

  assign stateClear = strobe.clear;
endmodule

// File: rtl/link_quiesce_ctrl_chk.sv
module link_quiesce_ctrl_chk #(
  parameter int TIMEOUT_CYC = 1024
) (
  input logic clk,
  input logic fundRstN,
  input logic cfgDoneN,
  input logic coreReady,
  input logic rstReqN,
  input logic txValid,
  input logic rxValid,
  input logic linkTxValid,
  input logic appRxValid,
  input logic resetStatusN,
  input logic warmRstRdy,
  input logic stateClear
);
  localparam int CW = $clog2(TIMEOUT_CYC + 3);
  localparam logic [CW-1:0] REQ_MAX = CW'(TIMEOUT_CYC + 1);

  logic chkRstN;
  logic [CW-1:0] reqCnt;
  assign chkRstN = fundRstN && !cfgDoneN;

  // Consecutive cycles of a pending, unacknowledged request
  always_ff @(posedge clk or negedge chkRstN) begin
    if (!chkRstN) reqCnt <= '0;
    else if (resetStatusN && !rstReqN && !warmRstRdy) begin
      if (reqCnt != '1) reqCnt <= reqCnt + CW'(1);
    end else reqCnt <= '0;
  end

  // R1
  always @(posedge clk) begin
    if (!chkRstN) begin
      held_in_reset_chk: assert (!resetStatusN && !linkTxValid && !appRxValid)
        else $error("reset source active but block not in reset");
    end
  end

  // R3
  reset_clears_chk: assert property (@(posedge clk) disable iff (!chkRstN)
    !resetStatusN |-> stateClear);

  // R5
  rx_gate_chk: assert property (@(posedge clk) disable iff (!chkRstN)
    appRxValid |-> (rxValid && rstReqN && resetStatusN));

  // R6
  tx_needs_valid_chk: assert property (@(posedge clk) disable iff (!chkRstN)
    linkTxValid |-> txValid);

  // R7
  req_blocks_paths_chk: assert property (@(posedge clk) disable iff (!chkRstN)
    !rstReqN |-> (!linkTxValid && !appRxValid));

  // R9
  flush_bounded_chk: assert property (@(posedge clk) disable iff (!chkRstN)
    reqCnt <= REQ_MAX);

  // R10
  ack_after_clear_chk: assert property (@(posedge clk) disable iff (!chkRstN)
    $rose(warmRstRdy) |-> $past(stateClear));

  // R11
  ack_holds_chk: assert property (@(posedge clk) disable iff (!chkRstN)
    (warmRstRdy && !rstReqN && coreReady) |=> warmRstRdy);

  // R11
  no_tx_after_ack_chk: assert property (@(posedge clk) disable iff (!chkRstN)
    ($fell(warmRstRdy) && resetStatusN) |-> !linkTxValid);

  // R12
  core_down_resets_chk: assert property (@(posedge clk) disable iff (!chkRstN)
    !coreReady |=> !resetStatusN);
endmodule

bind link_quiesce_ctrl link_quiesce_ctrl_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) chkInst (
  .clk         (clk),
  .fundRstN    (fundRstN),
  .cfgDoneN    (cfgDoneN),
  .coreReady   (coreReady),
  .rstReqN     (rstReqN),
  .txValid     (txValid),
  .rxValid     (rxValid),
  .linkTxValid (linkTxValid),
  .appRxValid  (appRxValid),
  .resetStatusN(resetStatusN),
  .warmRstRdy  (warmRstRdy),
  .stateClear  (stateClear)
);

// File: tb/link_quiesce_ctrl_test.sv
`timescale 1ns/1ps
module link_quiesce_ctrl_test;
  localparam int MAXO = 4;
  localparam int NT   = 2;
  localparam int TO   = 10;
  localparam int S_RESET = 0, S_WAIT = 1, S_RUN = 2, S_FLUSH = 3, S_ACK = 4;

  logic clk = 0;
  logic fundRstN, cfgDoneN, coreReady, rstReqN, busMasterEn;
  logic txValid, txNeedsTag, txDrained, tagRetire, rxValid;
  logic linkTxValid, appRxValid, resetStatusN, warmRstRdy, stateClear;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int mSync, mState, mOut, mTag, mTimer;
  logic mBmePrev;

  always #4 clk = ~clk;

  link_quiesce_ctrl #(.MAX_OUT(MAXO), .NUM_TAGS(NT), .TIMEOUT_CYC(TO)) uut (
    .clk(clk), .fundRstN(fundRstN), .cfgDoneN(cfgDoneN), .coreReady(coreReady),
    .rstReqN(rstReqN), .busMasterEn(busMasterEn), .txValid(txValid),
    .txNeedsTag(txNeedsTag), .txDrained(txDrained), .tagRetire(tagRetire),
    .rxValid(rxValid), .linkTxValid(linkTxValid), .appRxValid(appRxValid),
    .resetStatusN(resetStatusN), .warmRstRdy(warmRstRdy), .stateClear(stateClear));

  function automatic bit asyncRst();
    return !fundRstN || cfgDoneN;
  endfunction

  function automatic logic expTx();
    return txValid && mState == S_RUN && rstReqN && mOut < MAXO
           && (!txNeedsTag || mTag < NT);
  endfunction

  function automatic logic expRx();
    return rxValid && mState == S_RUN && rstReqN;
  endfunction

  function automatic logic expFlushDone();
    return mState == S_FLUSH && ((mOut == 0 && mTag == 0) || mTimer == TO - 1);
  endfunction

  function automatic logic expClr();
    return mState == S_RESET || expFlushDone();
  endfunction

  task automatic modelReset();
    mSync = 0; mState = S_RESET; mOut = 0; mTag = 0; mTimer = 0; mBmePrev = 1'b1;
  endtask

  task automatic modelEdge();
    int ns;
    logic tx, clr, rise;
    if (asyncRst()) begin modelReset(); return; end
    if (mSync < 2) begin mSync++; return; end
    tx = expTx(); clr = expClr(); rise = busMasterEn && !mBmePrev;
    ns = mState;
    case (mState)
      S_RESET: ns = S_WAIT;
      S_WAIT:  if (!rstReqN) ns = S_FLUSH; else if (rise) ns = S_RUN;
      S_RUN:   if (!rstReqN) ns = S_FLUSH;
      S_FLUSH: if (expFlushDone()) ns = S_ACK;
      S_ACK:   if (rstReqN) ns = S_WAIT;
      default: ns = S_RESET;
    endcase
    if (!coreReady) ns = S_RESET;
    if (clr) begin mOut = 0; mTag = 0; end
    else begin
      mOut = mOut + int'(tx) - int'(txDrained && mOut != 0);
      mTag = mTag + int'(tx && txNeedsTag) - int'(tagRetire && mTag != 0);
    end
    mTimer = (mState == S_FLUSH) ? mTimer + 1 : 0;
    mBmePrev = busMasterEn;
    mState = ns;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One cycle: compare all outputs against the model, then cross an edge
  task automatic tick();
    #1;
    if (asyncRst()) modelReset();
    chk(resetStatusN, logic'(mState != S_RESET), "R1", "resetStatusN");
    chk(linkTxValid, expTx(), "R6", "linkTxValid");
    chk(appRxValid, expRx(), "R5", "appRxValid");
    chk(warmRstRdy, logic'(mState == S_ACK), "R8", "warmRstRdy");
    chk(stateClear, expClr(), "R10", "stateClear");
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    fundRstN = 0; cfgDoneN = 1; coreReady = 1; rstReqN = 1; busMasterEn = 1;
    txValid = 0; txNeedsTag = 0; txDrained = 0; tagRetire = 0; rxValid = 0;
    modelReset();
    @(negedge clk);
    repeat (3) tick();
    #1 chk(resetStatusN, 0, "R1", "held by fundamental reset");
    chk(stateClear, 1, "R3", "clear during reset");

    fundRstN = 1;  // configuration still pending
    repeat (4) tick();
    #1 chk(resetStatusN, 0, "R1", "held by cfgDoneN");

    cfgDoneN = 0;
    repeat (2) tick();
    #1 chk(resetStatusN, 0, "R1", "low after two edges");
    tick();
    #1 chk(resetStatusN, 1, "R1", "high after third edge");

    // stale enable level must not open the path
    txValid = 1;
    #1 chk(linkTxValid, 0, "R4", "stale enable keeps tx closed");
    tick();
    busMasterEn = 0; tick();
    busMasterEn = 1; tick();
    #1 chk(linkTxValid, 1, "R4", "tx open after enable edge");

    repeat (4) tick();
    #1 chk(linkTxValid, 0, "R6", "outstanding limit blocks tx");
    txValid = 0; txDrained = 1;
    repeat (2) tick();
    txDrained = 0;
    rxValid = 1;
    #1 chk(appRxValid, 1, "R5", "rx delivered while running");

    // request collides with tx and rx strobes
    txValid = 1; rstReqN = 0;
    #1 chk(linkTxValid, 0, "R7", "tx blocked in request cycle");
    chk(appRxValid, 0, "R7", "rx dropped in request cycle");
    txValid = 0; rxValid = 0;
    tick();
    n = 0;
    for (int i = 0; i < 40; i++) begin
      #1;
      if (warmRstRdy) break;
      tick();
      n++;
    end
    checks++;
    if (n != TO) begin
      errors++;
      $display("FAIL R9 timeout ack: actual %0d expected %0d cycles", n, TO);
    end

    repeat (3) tick();
    #1 chk(warmRstRdy, 1, "R11", "ack held while request low");
    rstReqN = 1;
    tick();
    #1 chk(warmRstRdy, 0, "R11", "ack drops after request release");
    txValid = 1;
    #1 chk(linkTxValid, 0, "R11", "tx closed awaiting enable edge");
    repeat (2) tick();
    busMasterEn = 0; tick();
    busMasterEn = 1; tick();
    #1 chk(linkTxValid, 1, "R4", "tx reopened by new edge");
    txValid = 0;

    coreReady = 0; tick();
    #1 chk(resetStatusN, 0, "R12", "core down forces reset");
    chk(stateClear, 1, "R3", "clear while core down");
    coreReady = 1; tick();
    #1 chk(resetStatusN, 1, "R12", "reset left when core up");

    fundRstN = 0;
    #1 chk(resetStatusN, 0, "R2", "asynchronous assertion");
    tick();
    fundRstN = 1;
    repeat (3) tick();

    // random phase
    void'($urandom(32'd20240611));
    for (int c = 0; c < 6000; c++) begin
      txValid    = ($urandom % 2) == 0;
      txNeedsTag = ($urandom % 2) == 0;
      txDrained  = ($urandom % 3) == 0;
      tagRetire  = ($urandom % 3) == 0;
      rxValid    = ($urandom % 2) == 0;
      if (($urandom % 12) == 0) busMasterEn = ~busMasterEn;
      if (rstReqN) begin if (($urandom % 40) == 0) rstReqN = 0; end
      else if (($urandom % 14) == 0) rstReqN = 1;
      coreReady = ($urandom % 250) != 0;
      fundRstN  = ($urandom % 600) != 0;
      cfgDoneN  = ($urandom % 900) == 0;
      tick();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule